// File: doc/BRIEF.md
# Serial Audio Bit-Clock Source Selector

This block chooses where the bit clock of a serial audio input comes from. When an external bit clock is present, the block follows it. When none is present, the block derives an internal bit clock from the master clock (MCLK) and keeps it in step with the word-select clock (LRCK). All logic runs on MCLK. Both LRCK and the external bit clock are treated as asynchronous and pass through synchronizers before any decision uses them.

The switch to the external clock happens once enough rising edges of that clock fall inside a single LRCK half-period. The block falls back to the internal clock after the external clock has been silent for two full LRCK periods. The internal clock's MCLK divide depends on two static codes: the MCLK-to-LRCK ratio and the data format. Both codes are latched at each LRCK transition.

Every pin is a plain level signal. No sample data crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `sclk_source_sel`

## Requirements
- R1: While reset is asserted, and after its release, `ext_mode` is 0 and `sclk_out` is low. Until the first LRCK transition, the internal clock uses a half period of 4 MCLK cycles, so the full period is 8.
- R2: `ext_mode` becomes 1 on the 16th synchronized rising edge of `sclk_in` within one LRCK half-period. 15 rising edges in a half-period leave it at 0.
- R3: The rising-edge count restarts at every LRCK transition. Any number of half-periods with 15 rising edges each never selects the external clock.
- R4: In external mode, `ext_mode` returns to 0 at the 4th LRCK transition seen without any intervening `sclk_in` rising edge, which is two full LRCK periods. After 3 such transitions it is still 1.
- R5: In external mode, `sclk_out` equals `sclk_in` as sampled three MCLK rising edges earlier.
- R6: In internal mode, an LRCK transition drives `sclk_out` low on the third MCLK rising edge after the transition. `sclk_out` then rises after one half period and toggles every half period from there on.
- R7: `ratio_code` encodes MCLK/LRCK as follows: 0=128, 1=192, 2=256, 3=384, 4=512, and 5 to 7 act as 256. `fmt_code` encodes the format as follows: 0=I2S, 1=left-justified 24-bit, 2=right-justified 24-bit, 3=right-justified 16-bit. For ratios 128, 256 and 512 with format 0 or 3, the internal clock runs at 32 periods per LRCK period.
- R8: For ratios 192 and 384, the internal clock runs at 48 periods per LRCK period for every format.
- R9: For ratios 128, 256 and 512 with format 1 or 2, the internal clock runs at 64 periods per LRCK period.
- R10: A change of `ratio_code` or `fmt_code` in the middle of a half-period leaves the current internal period unchanged. The new period takes effect from the next LRCK transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (MCLK); all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Word-select clock, asynchronous to MCLK |
| sclk_in | input | 1 | External bit clock, asynchronous; may be absent |
| ratio_code | input | 3 | MCLK/LRCK ratio code, static (see R7) |
| fmt_code | input | 2 | Data format code, static (see R7) |
| sclk_out | output | 1 | Selected bit clock, in the MCLK domain |
| ext_mode | output | 1 | 1 when the external bit clock is selected |

## Verification
A stuck or miscounted edge counter shows up at `ext_mode` within one LRCK half-period. Either the flag rises on too few edges, or it fails to rise on the 16th. A wrong silence counter moves the fall of `ext_mode` by whole LRCK transitions, which is visible at the fourth transition after the external clock stops. A wrong latched divide or a missed restart changes the `sclk_out` period or phase within a few MCLK cycles of the next LRCK transition. Comparing against a reference model on every MCLK cycle pins each of these faults to the exact cycle.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ24 = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_RJ16 = 2'd3
  } fmt_e;

  localparam int HALF_W = 4;

  // Half period of the internal bit clock in MCLK cycles.
  function automatic logic [HALF_W-1:0] half_period(logic [2:0] rc, logic [1:0] fc);
    int m;
    int s;
    case (rc)
      3'd0:    m = 128;
      3'd1:    m = 192;
      3'd3:    m = 384;
      3'd4:    m = 512;
      default: m = 256;
    endcase
    if (rc == 3'd1 || rc == 3'd3)                              s = 48;
    else if (fc == FMT_LJ24 || fc == FMT_RJ24)                 s = 64;
    else                                                       s = 32;
    return HALF_W'(m / (2 * s));
  endfunction

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic cur,
  output logic dly
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign cur = sh[STAGES-1];
  assign dly = sh[STAGES];
endmodule

// File: rtl/sclk_mode_det.sv
module sclk_mode_det #(
  parameter int ENTER_EDGES  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_rise,
  input  logic lrck_edge,
  output logic ext_mode
);
  localparam int CW        = $clog2(ENTER_EDGES + 1);
  localparam int IDLE_EDGE = 2 * IDLE_PERIODS;
  localparam int IW        = $clog2(IDLE_EDGE + 1);
  localparam logic [CW-1:0] ENTER_C = CW'(ENTER_EDGES);
  localparam logic [IW-1:0] IDLE_C  = IW'(IDLE_EDGE);

  logic [CW-1:0] cnt, cnt_base, cnt_next;
  logic [IW-1:0] idle;
  logic          hit, timeout;

  always_comb begin
    cnt_base = lrck_edge ? '0 : cnt;
    cnt_next = cnt_base;
    if (sclk_rise && cnt_base != ENTER_C) cnt_next = cnt_base + 1'b1;
  end

  assign hit     = sclk_rise && (cnt_next == ENTER_C);
  assign timeout = !sclk_rise && lrck_edge && (idle == IDLE_C - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      idle     <= '0;
      ext_mode <= 1'b0;
    end else begin
      cnt <= cnt_next;
      if (sclk_rise)                        idle <= '0;
      else if (lrck_edge && idle != IDLE_C) idle <= idle + 1'b1;
      if (hit)          ext_mode <= 1'b1;
      else if (timeout) ext_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/sclk_int_gen.sv
module sclk_int_gen
  import sclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_edge,
  input  logic [2:0] ratio_code,
  input  logic [1:0] fmt_code,
  output logic       sclk_int
);
  localparam logic [HALF_W-1:0] HALF_RST = half_period(3'd2, 2'd0);

  logic [HALF_W-1:0] half_q, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= HALF_RST;
      cnt      <= '0;
      sclk_int <= 1'b0;
    end else if (lrck_edge) begin
      half_q   <= half_period(ratio_code, fmt_code);
      cnt      <= '0;
      sclk_int <= 1'b0;
    end else if (cnt == half_q - 1'b1) begin
      cnt      <= '0;
      sclk_int <= ~sclk_int;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclk_source_sel.sv
module sclk_source_sel #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_EDGES  = 16,
  parameter int IDLE_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_in,
  input  logic       sclk_in,
  input  logic [2:0] ratio_code,
  input  logic [1:0] fmt_code,
  output logic       sclk_out,
  output logic       ext_mode
);
  logic lrck_cur, lrck_dly, sclk_cur, sclk_dly;
  logic lrck_edge, sclk_rise, sclk_int;

  sclk_sync #(.STAGES(SYNC_STAGES)) u_lrck_sync (
    .clk(clk), .rst_n(rst_n), .d(lrck_in), .cur(lrck_cur), .dly(lrck_dly)
  );

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk_in), .cur(sclk_cur), .dly(sclk_dly)
  );

  assign lrck_edge = lrck_cur ^ lrck_dly;
  assign sclk_rise = sclk_cur & ~sclk_dly;

  sclk_mode_det #(.ENTER_EDGES(ENTER_EDGES), .IDLE_PERIODS(IDLE_PERIODS)) u_det (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .lrck_edge(lrck_edge),
    .ext_mode(ext_mode)
  );

  sclk_int_gen u_gen (
    .clk(clk), .rst_n(rst_n), .lrck_edge(lrck_edge), .ratio_code(ratio_code),
    .fmt_code(fmt_code), .sclk_int(sclk_int)
  );

  assign sclk_out = ext_mode ? sclk_dly : sclk_int;
endmodule

// File: rtl/sclk_source_chk.sv
module sclk_source_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_mode,
  input logic sclk_rise,
  input logic lrck_edge,
  input logic sclk_int
);
  always @(posedge clk) begin
    if (!rst_n) begin
      // R1
      reset_internal_chk: assert (ext_mode == 1'b0);
    end
  end

  // R2
  enter_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> $past(sclk_rise));

  // R4
  exit_on_lrck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode) |-> ($past(lrck_edge) && !$past(sclk_rise)));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_rise && !lrck_edge) |=> $stable(ext_mode));

  // R6
  int_restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_edge |=> !sclk_int);
endmodule

bind sclk_source_sel sclk_source_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sclk_rise(sclk_rise),
  .lrck_edge(lrck_edge), .sclk_int(sclk_int)
);

// File: tb/tb_sclk_source_sel.sv
`timescale 1ns/1ps
module tb_sclk_source_sel;
  localparam real CLK_PER = 20.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck_in = 1'b0;
  logic sclk_in = 1'b0;
  logic [2:0] ratio_code = 3'd2;
  logic [1:0] fmt_code = 2'd0;
  logic sclk_out, ext_mode;

  always #(CLK_PER/2) clk = ~clk;

  sclk_source_sel dut (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .sclk_in(sclk_in),
    .ratio_code(ratio_code), .fmt_code(fmt_code),
    .sclk_out(sclk_out), .ext_mode(ext_mode)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- stimulus generator ----------------
  bit gen_en = 0;
  int lrck_half = 128;
  int per_phase = 0;
  int ext_half = 2;
  int lr_cnt = 0, sc_cnt = 0, rises_left = 0;
  int tog_cnt = 0;

  always @(posedge clk) begin
    #1;
    if (gen_en) begin
      lr_cnt++;
      if (lr_cnt >= lrck_half) begin
        lr_cnt = 0;
        lrck_in = ~lrck_in;
        rises_left = per_phase;
        tog_cnt++;
      end
      sc_cnt++;
      if (sc_cnt >= ext_half) begin
        sc_cnt = 0;
        if (sclk_in) sclk_in = 1'b0;
        else if (rises_left > 0) begin
          sclk_in = 1'b1;
          rises_left--;
        end
      end
    end
  end

  // ---------------- reference model ----------------
  bit lq[$], sq[$];
  int m_cnt, m_idle, m_ic, m_half;
  bit m_ext, m_sck, m_out;

  function automatic int ref_half(int rc, int fc);
    int m, s;
    m = (rc == 0) ? 128 : (rc == 1) ? 192 : (rc == 3) ? 384 : (rc == 4) ? 512 : 256;
    if (m == 192 || m == 384) s = 48;
    else if (fc == 1 || fc == 2) s = 64;
    else s = 32;
    return m / s / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lq = '{0, 0, 0}; sq = '{0, 0, 0};
      m_cnt = 0; m_idle = 0; m_ic = 0; m_half = 4;
      m_ext = 0; m_sck = 0; m_out = 0;
    end else begin
      bit le, sr;
      le = lq[1] ^ lq[0];
      sr = sq[1] & ~sq[0];
      lq.push_back(lrck_in); void'(lq.pop_front());
      sq.push_back(sclk_in); void'(sq.pop_front());
      if (le) m_cnt = 0;
      if (sr) begin
        if (m_cnt < 16) m_cnt++;
        if (m_cnt >= 16) m_ext = 1;
        m_idle = 0;
      end else if (le) begin
        if (m_idle < 4) m_idle++;
        if (m_idle == 4 && m_ext) m_ext = 0;
      end
      if (le) begin
        m_ic = 0; m_sck = 0; m_half = ref_half(ratio_code, fmt_code);
      end else if (m_ic == m_half - 1) begin
        m_ic = 0; m_sck = ~m_sck;
      end else m_ic++;
      m_out = m_ext ? sq[0] : m_sck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ext_mode === m_ext, {cur_req, " ext_mode model"}, ext_mode, m_ext);
      check(sclk_out === m_out, {cur_req, " sclk_out model"}, sclk_out, m_out);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wait_togs(int n);
    int t = tog_cnt;
    wait (tog_cnt == t + n);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(int exp, string req);
    int n = 0;
    bit prev;
    @(negedge clk);
    while (sclk_out !== 1'b0) @(negedge clk);
    while (sclk_out !== 1'b1) @(negedge clk);
    prev = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (sclk_out && !prev) break;
      prev = sclk_out;
    end
    check(n == exp, {req, " period"}, n, exp);
  endtask

  task automatic set_ratio(int rc, int fc, int lh, string req);
    cur_req = req;
    ratio_code = 3'(rc); fmt_code = 2'(fc); lrck_half = lh;
    wait_togs(2);
    cycles(4);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    cycles(3);
    check(ext_mode === 1'b0, "R1 reset ext_mode", ext_mode, 0);
    check(sclk_out === 1'b0, "R1 reset sclk_out", sclk_out, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    check(ext_mode === 1'b0, "R1 after release ext_mode", ext_mode, 0);
    gen_en = 1;
    measure(8, "R1");

    // R6 restart phase
    cur_req = "R6";
    wait_togs(1);
    wait (sclk_out == 1'b1);
    wait_togs(1);
    cycles(4);
    check(sclk_out === 1'b0, "R6 low after LRCK edge", sclk_out, 0);
    cycles(3);
    check(sclk_out === 1'b0, "R6 still low", sclk_out, 0);
    cycles(1);
    check(sclk_out === 1'b1, "R6 first rise", sclk_out, 1);

    set_ratio(2, 0, 128, "R7"); measure(8, "R7 256/I2S");
    set_ratio(0, 0, 64, "R7");  measure(4, "R7 128/I2S");
    set_ratio(4, 3, 256, "R7"); measure(16, "R7 512/RJ16");
    set_ratio(1, 1, 96, "R8");  measure(4, "R8 192/LJ24");
    set_ratio(3, 2, 192, "R8"); measure(8, "R8 384/RJ24");
    set_ratio(0, 1, 64, "R9");  measure(2, "R9 128/LJ24");
    set_ratio(4, 2, 256, "R9"); measure(8, "R9 512/RJ24");
    set_ratio(2, 2, 128, "R9"); measure(4, "R9 256/RJ24");

    // R10 mid-phase change
    set_ratio(2, 0, 128, "R10");
    wait_togs(1);
    cycles(20);
    fmt_code = 2'd1;
    measure(8, "R10 before next LRCK edge");
    wait_togs(1);
    cycles(4);
    measure(4, "R10 after next LRCK edge");
    fmt_code = 2'd0;
    wait_togs(2);

    // R2/R3: 15 rises per phase never enters
    cur_req = "R3";
    per_phase = 15;
    wait_togs(5);
    cycles(10);
    check(ext_mode === 1'b0, "R3 fifteen per phase", ext_mode, 0);
    check(ext_mode === 1'b0, "R2 fifteen edges no entry", ext_mode, 0);

    cur_req = "R2";
    per_phase = 16;
    wait_togs(2);
    cycles(10);
    check(ext_mode === 1'b1, "R2 sixteen edges enter", ext_mode, 1);

    // R5 follow external clock
    cur_req = "R5";
    per_phase = 1000;
    wait_togs(1);
    begin
      bit h[$];
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        h.push_back(sclk_in);
        if (h.size() > 3) begin
          check(sclk_out === h[0], "R5 follows sclk_in", sclk_out, h[0]);
          void'(h.pop_front());
        end
      end
    end

    // R4 timeout
    cur_req = "R4";
    per_phase = 0;
    wait_togs(1);
    wait_togs(2);
    cycles(10);
    check(ext_mode === 1'b1, "R4 three silent edges", ext_mode, 1);
    wait_togs(1);
    cycles(10);
    check(ext_mode === 1'b0, "R4 four silent edges", ext_mode, 0);
    measure(8, "R4 internal again");

    cycles(20);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 190000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule